// File: doc/BRIEF.md
# Normalization Exponent Detector with Block Compare

This block measures how far a 16-bit fixed-point operand can be shifted left before its top bit stops being a sign bit. It turns that measure into a signed normalization exponent, zero or negative. A shifter then uses this exponent to normalize the operand.

Three interpretations are offered. The plain mode treats the operand as a single-precision word or the upper word of a double. The overflow-aware mode treats it as the upper word of an adder result that may have overflowed. The lower-word mode treats it as the low word of a double, after the upper word has been processed. A derive strobe stores the result in an 8-bit exponent register. In the plain and overflow-aware modes it also latches a sign flag. A separate block strobe keeps, in a 5-bit block register, the largest exponent seen so far, which serves block floating-point scaling.

Both registers can be loaded directly. Both are presented sign-extended to 16 bits.

Top module: `norm_exp_unit`

## Requirements
- R1: With mode code 0 (plain), or the unused code 3, which behaves identically, `exp_out` equals one minus the length of the leading run of bits equal to bit 15, giving 0 down to -15. An all-sign operand gives -15.
- R2: With mode code 1 (overflow-aware) and `ovf_in` high, `exp_out` is +1 for any operand. With `ovf_in` low, mode 1 gives the same result as mode 0.
- R3: `sign_out` equals operand bit 15 in modes 0, 1 and 3, and its inverse in mode 1 when `ovf_in` is high. In mode code 2 (lower word), it equals the stored `sign_flag`.
- R4: In mode 2, `exp_out` equals -15 minus the number of leading bits, from bit 15 down, that match `sign_flag`. This gives -15 when bit 15 differs and -31 when all 16 bits match.
- R5: On a derive strobe in modes 0, 1 or 3, the exponent register takes `exp_out` and `sign_flag` takes `sign_out`. In mode 2, the exponent register takes `exp_out` only if it currently holds -15, and `sign_flag` is left unchanged.
- R6: On a block strobe, the block register takes `exp_out` only when `exp_out` is strictly greater, as a signed value, than its current contents.
- R7: `exp_load` writes `load_data` into the exponent register, and `blk_load` writes `load_data[4:0]` into the block register. Each load overrides a derive or block strobe on the same register in the same cycle.
- R8: `exp_rd` and `blk_rd` present the exponent and block registers sign-extended to 16 bits.
- R9: After a clock with `rst_n` low, the exponent register is 0, the block register is -16 and `sign_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| operand | input | 16 | Value whose exponent is derived |
| mode | input | 2 | 0 plain, 1 overflow-aware, 2 lower word, 3 as 0 |
| ovf_in | input | 1 | Adder overflow status, used in mode 1 |
| derive | input | 1 | Store derived exponent (and sign flag) |
| blk_derive | input | 1 | Compare derived exponent into block register |
| exp_load | input | 1 | Load exponent register from `load_data` |
| blk_load | input | 1 | Load block register from `load_data[4:0]` |
| load_data | input | 8 | Value for direct loads |
| exp_out | output | 8 | Derived exponent, two's complement, combinational |
| sign_out | output | 1 | Derived sign, combinational |
| sign_flag | output | 1 | Stored sign flag |
| exp_rd | output | 16 | Exponent register, sign-extended |
| blk_rd | output | 16 | Block register, sign-extended |

## Verification
The register properties exclude cycles in which a direct load hits the same register. The lower-word write guard and the claim that the block register never falls therefore hold only when no load is in flight. The sign-hold property likewise assumes that no derive occurs outside mode 2 in that cycle.

The random stimulus keeps loads rare, at one cycle in sixteen, so long stretches run without a load. Operands are arithmetic-shifted right by a random amount, which produces leading sign runs of every length. All four mode codes and both overflow levels are drawn.

// File: rtl/expdet_pkg.sv
// Shared mode encoding for the normalization exponent detector.
package expdet_pkg;
    typedef enum logic [1:0] {
        MODE_HI  = 2'd0,
        MODE_HIX = 2'd1,
        MODE_LO  = 2'd2,
        MODE_RSV = 2'd3
    } exp_mode_e;
endpackage

// File: rtl/lead_match_count.sv
// Counts how many bits, starting at the MSB, equal ref_bit before the first mismatch.
// Assumes CW is wide enough to hold W.
module lead_match_count #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  data,
    input  logic          ref_bit,
    output logic [CW-1:0] count
);
    // Walk down from the MSB while the run of matching bits continues.
    always_comb begin
        logic run;
        run   = 1'b1;
        count = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (run && (data[i] == ref_bit))
                count = count + CW'(1);
            else
                run = 1'b0;
        end
    end
endmodule

// File: rtl/exp_derive.sv
// Maps the leading-run length to a signed exponent and a sign bit per mode.
// Assumes EW is wider than the count width; mode 3 is treated as the plain mode.
module exp_derive
    import expdet_pkg::*;
#(
    parameter int DW = 16,
    parameter int EW = 8
) (
    input  logic [DW-1:0] operand,
    input  exp_mode_e     mode,
    input  logic          ovf_in,
    input  logic          stored_sign,
    output logic [EW-1:0] exp_val,
    output logic          sign_val
);
    localparam int CW = $clog2(DW + 1);
    localparam logic signed [EW-1:0] LO_BASE = EW'(-(DW - 1));
    localparam logic signed [EW-1:0] ONE     = EW'(1);

    logic          ref_bit;
    logic [CW-1:0] run_len;
    logic signed [EW-1:0] run_s;
    logic          ovf_hit;

    assign ref_bit = (mode == MODE_LO) ? stored_sign : operand[DW-1];
    assign run_s   = $signed({{(EW - CW){1'b0}}, run_len});
    assign ovf_hit = (mode == MODE_HIX) && ovf_in;

    lead_match_count #(.W(DW), .CW(CW)) i_count (
        .data    (operand),
        .ref_bit (ref_bit),
        .count   (run_len)
    );

    // Select the exponent formula for the current mode.
    always_comb begin
        if (mode == MODE_LO)
            exp_val = LO_BASE - run_s;
        else if (ovf_hit)
            exp_val = ONE;
        else
            exp_val = ONE - run_s;
    end

    // Select the sign reported with the exponent.
    always_comb begin
        if (mode == MODE_LO)
            sign_val = stored_sign;
        else if (ovf_hit)
            sign_val = ~operand[DW-1];
        else
            sign_val = operand[DW-1];
    end
endmodule

// File: rtl/exp_store.sv
// Holds the exponent register, the block register and the sign flag.
// Assumes new_exp fits BW bits whenever it exceeds the block register's value.
module exp_store #(
    parameter int DW = 16,
    parameter int EW = 8,
    parameter int BW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          derive,
    input  logic          blk_derive,
    input  logic          exp_load,
    input  logic          blk_load,
    input  logic [EW-1:0] load_data,
    input  logic          is_lo,
    input  logic [EW-1:0] new_exp,
    input  logic          new_sign,
    output logic [EW-1:0] exp_reg,
    output logic [BW-1:0] blk_reg,
    output logic          sign_flag
);
    localparam logic [EW-1:0] LO_GATE = EW'(-(DW - 1));
    localparam logic [BW-1:0] BLK_MIN = {1'b1, {(BW - 1){1'b0}}};

    logic blk_wider_lt;
    assign blk_wider_lt = $signed(new_exp) > $signed({{(EW - BW){blk_reg[BW-1]}}, blk_reg});

    // Exponent register: load first, then derive with the lower-word guard.
    always_ff @(posedge clk) begin
        if (!rst_n)
            exp_reg <= '0;
        else if (exp_load)
            exp_reg <= load_data;
        else if (derive && (!is_lo || exp_reg == LO_GATE))
            exp_reg <= new_exp;
    end

    // Sign flag: written only by upper-word derives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sign_flag <= 1'b0;
        else if (derive && !is_lo)
            sign_flag <= new_sign;
    end

    // Block register: load first, then keep the larger exponent.
    always_ff @(posedge clk) begin
        if (!rst_n)
            blk_reg <= BLK_MIN;
        else if (blk_load)
            blk_reg <= load_data[BW-1:0];
        else if (blk_derive && blk_wider_lt)
            blk_reg <= new_exp[BW-1:0];
    end
endmodule

// File: rtl/norm_exp_unit.sv
// Top: derives a normalization exponent and maintains exponent and block registers.
// Assumes one operation set per cycle; readouts are sign-extended to DW bits.
module norm_exp_unit
    import expdet_pkg::*;
#(
    parameter int DW = 16,
    parameter int EW = 8,
    parameter int BW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] operand,
    input  logic [1:0]    mode,
    input  logic          ovf_in,
    input  logic          derive,
    input  logic          blk_derive,
    input  logic          exp_load,
    input  logic          blk_load,
    input  logic [EW-1:0] load_data,
    output logic [EW-1:0] exp_out,
    output logic          sign_out,
    output logic          sign_flag,
    output logic [DW-1:0] exp_rd,
    output logic [DW-1:0] blk_rd
);
    exp_mode_e     mode_e;
    logic [EW-1:0] exp_reg;
    logic [BW-1:0] blk_reg;

    assign mode_e = exp_mode_e'(mode);

    exp_derive #(.DW(DW), .EW(EW)) i_derive (
        .operand     (operand),
        .mode        (mode_e),
        .ovf_in      (ovf_in),
        .stored_sign (sign_flag),
        .exp_val     (exp_out),
        .sign_val    (sign_out)
    );

    exp_store #(.DW(DW), .EW(EW), .BW(BW)) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .derive     (derive),
        .blk_derive (blk_derive),
        .exp_load   (exp_load),
        .blk_load   (blk_load),
        .load_data  (load_data),
        .is_lo      (mode_e == MODE_LO),
        .new_exp    (exp_out),
        .new_sign   (sign_out),
        .exp_reg    (exp_reg),
        .blk_reg    (blk_reg),
        .sign_flag  (sign_flag)
    );

    // Sign-extend both registers onto the readout width.
    assign exp_rd = {{(DW - EW){exp_reg[EW-1]}}, exp_reg};
    assign blk_rd = {{(DW - BW){blk_reg[BW-1]}}, blk_reg};
endmodule

// File: rtl/norm_exp_unit_chk.sv
// Checker for norm_exp_unit; observes ports only and is bound to the top.
module norm_exp_unit_chk #(
    parameter int DW = 16,
    parameter int EW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] operand,
    input logic [1:0]    mode,
    input logic          ovf_in,
    input logic          derive,
    input logic          blk_derive,
    input logic          exp_load,
    input logic          blk_load,
    input logic [EW-1:0] exp_out,
    input logic          sign_out,
    input logic          sign_flag,
    input logic [DW-1:0] exp_rd,
    input logic [DW-1:0] blk_rd
);
    localparam logic [DW-1:0] RD_GATE = DW'(-(DW - 1));

    // R1: plain mode never yields a positive exponent or one below -(DW-1).
    a_r1_hi_range: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> ($signed(exp_out) <= 0 && $signed(exp_out) >= -(DW - 1)));

    // R2: overflow-aware mode with overflow yields +1.
    a_r2_hix_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && ovf_in) |-> (exp_out == EW'(1)));

    // R3: overflow restores the inverted sign.
    a_r3_ovf_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && ovf_in) |-> (sign_out != operand[DW-1]));

    // R5: a lower-word derive leaves the register alone unless it holds -15.
    a_r5_lo_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (derive && mode == 2'd2 && !exp_load && exp_rd != RD_GATE) |=> $stable(exp_rd));

    // R5: the sign flag holds when no upper-word derive occurs.
    a_r5_sign_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(derive && mode != 2'd2)) |=> $stable(sign_flag));

    // R6: without a load the block register never decreases.
    a_r6_blk_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_load) |=> ($signed(blk_rd) >= $signed($past(blk_rd))));

    // R6: without a block strobe or load the block register holds.
    a_r6_blk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_load && !blk_derive) |=> $stable(blk_rd));
endmodule

bind norm_exp_unit norm_exp_unit_chk #(.DW(DW), .EW(EW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .operand    (operand),
    .mode       (mode),
    .ovf_in     (ovf_in),
    .derive     (derive),
    .blk_derive (blk_derive),
    .exp_load   (exp_load),
    .blk_load   (blk_load),
    .exp_out    (exp_out),
    .sign_out   (sign_out),
    .sign_flag  (sign_flag),
    .exp_rd     (exp_rd),
    .blk_rd     (blk_rd)
);

// File: tb/test_norm_exp_unit.sv
module test_norm_exp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] operand = '0;
    logic [1:0]  mode = '0;
    logic        ovf_in = 1'b0, derive = 1'b0, blk_derive = 1'b0;
    logic        exp_load = 1'b0, blk_load = 1'b0;
    logic [7:0]  load_data = '0;
    logic [7:0]  exp_out;
    logic        sign_out, sign_flag;
    logic [15:0] exp_rd, blk_rd;

    int checks = 0, errors = 0;
    int m_exp = 0, m_blk = -16;
    logic m_sf = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    norm_exp_unit i_norm_exp_unit (
        .clk(clk), .rst_n(rst_n), .operand(operand), .mode(mode), .ovf_in(ovf_in),
        .derive(derive), .blk_derive(blk_derive), .exp_load(exp_load), .blk_load(blk_load),
        .load_data(load_data), .exp_out(exp_out), .sign_out(sign_out), .sign_flag(sign_flag),
        .exp_rd(exp_rd), .blk_rd(blk_rd)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int run_len(input logic [15:0] op, input logic rb);
        int n = 0;
        for (int i = 15; i >= 0; i--) begin
            if (op[i] != rb) break;
            n++;
        end
        return n;
    endfunction

    function automatic int ref_exp(input logic [15:0] op, input logic [1:0] md, input logic ov, input logic sf);
        if (md == 2'd2) return -15 - run_len(op, sf);
        if (md == 2'd1 && ov) return 1;
        return 1 - run_len(op, op[15]);
    endfunction

    function automatic logic ref_sign(input logic [15:0] op, input logic [1:0] md, input logic ov, input logic sf);
        if (md == 2'd2) return sf;
        if (md == 2'd1 && ov) return ~op[15];
        return op[15];
    endfunction

    task automatic step(input logic [15:0] op, input logic [1:0] md, input logic ov,
                        input logic der, input logic bder, input logic el, input logic bl,
                        input logic [7:0] ld);
        int d;
        logic s;
        @(negedge clk);
        operand = op; mode = md; ovf_in = ov; derive = der; blk_derive = bder;
        exp_load = el; blk_load = bl; load_data = ld;
        #2;
        d = ref_exp(op, md, ov, m_sf);
        s = ref_sign(op, md, ov, m_sf);
        if (md == 2'd2)      check("R4", int'($signed(exp_out)), d);
        else if (md == 2'd1) check("R2", int'($signed(exp_out)), d);
        else                 check("R1", int'($signed(exp_out)), d);
        check("R3", int'(sign_out), int'(s));
        // register model from R5, R6 and R7
        if (el) m_exp = int'($signed(ld));
        else if (der && (md != 2'd2 || m_exp == -15)) m_exp = d;
        if (der && md != 2'd2) m_sf = s;
        if (bl) m_blk = int'($signed(ld[4:0]));
        else if (bder && d > m_blk) m_blk = d;
        @(posedge clk);
        #2;
        check(el ? "R7" : "R5", int'($signed(exp_rd)), m_exp);
        check("R5", int'(sign_flag), int'(m_sf));
        check(bl ? "R7" : "R6", int'($signed(blk_rd)), m_blk);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5071));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R9", int'($signed(exp_rd)), 0);
        check("R9", int'($signed(blk_rd)), -16);
        check("R9", int'(sign_flag), 0);
        // directed corners
        step(16'h0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00); // R1 all sign -> -15
        step(16'hFFFF, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00); // R1 code 3
        step(16'h4000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00); // R6 block up to 0
        step(16'h0001, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00); // R6 -14 not larger
        step(16'h2000, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00); // R2 no overflow
        step(16'h8000, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00); // R2 +1, R3 inverted
        step(16'h0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00); // back to -15, flag 0
        step(16'h0001, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00); // R4 -30 written
        step(16'h8000, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00); // R5 guard blocks
        step(16'h0000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00); // R4 -31
        step(16'h0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h80); // R7 load wins, R8 -128
        check("R8", int'(exp_rd), 32'h0000FF80);
        step(16'h1234, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h10); // R7 block load wins
        check("R8", int'(blk_rd), 32'h0000FFF0);
        // constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] r;
            logic [3:0]  ls;
            r  = 16'($urandom);
            ls = 4'($urandom);
            step(16'($signed(r) >>> ($urandom % 17)), 2'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), ls == 4'd0, ls == 4'd1, 8'($urandom));
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule